// File: doc/BRIEF.md
# Programmable Channel Clock Divider with Sync Phase Offset

This block divides one of two prescaled input rates by a programmable integer and drives a divided clock out. Both prescaled rates arrive as single-cycle enable strobes on one fast system clock. The divider counts only the strobes of the source it has selected, so no clock multiplexer is needed. A small byte-wide register bank holds the ratio, the source select, a power-down control and an initial phase offset.

Several channels can share one synchronization pulse. On that pulse each channel drops its output and restarts. Its first rising edge comes after a programmed number of input periods, which lines up the edges of all channels that received the same pulse. A new ratio written while the divider runs is taken at the end of the current output period, so the output never produces a shortened pulse.

Top module: `chan_clk_div`

## Requirements
- R1: The ratio field is 10 bits wide. Address 0 holds bits [7:0] and address 1 bits [1:0] hold bits [9:8]. The output period is (field + 1) ticks of the selected source, so 0 divides by 1 and 1023 divides by 1024.
- R2: For a ratio N of 2 or more, the output is high for floor(N/2) ticks of each period, which gives 50% duty for even N. For N = 1, the output is high for the one clock cycle after each tick and low otherwise.
- R3: The phase field is address 2 bits [5:0]. From the cycle after a sync pulse the output is low. It rises with the (phase + 1)-th tick after the sync.
- R4: After reset all fields are zero (divide by 1, phase 0, running, first source) and the output stays low until the first sync pulse.
- R5: Address 1 bit 4 is power-down. While it is set the output is low from the next cycle on, and sync pulses are ignored.
- R6: Clearing power-down leaves the output low until the next sync pulse. That pulse then behaves as in R3.
- R7: A ratio written without a sync completes the running period at the old ratio. The new ratio applies from the next period.
- R8: Address 1 bit 5 selects the source: 0 is strobe A and 1 is strobe B. The output only rises on a tick of the selected source, and changing the select moves the count to the other strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pre_a_en | input | 1 | Tick strobe of prescaled source A |
| pre_b_en | input | 1 | Tick strobe of prescaled source B |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register byte address |
| cfg_wdata | input | 8 | Register write data |
| sync_in | input | 1 | Synchronization pulse, one cycle |
| div_out | output | 1 | Divided output clock |

## Verification
The bench covers the ratio extremes of 1 and 1024 and the odd ratios 3 and 7. An off-by-one in the field+1 encoding or in the high-time compare shows up there as a wrong period or a stretched or shortened high phase. The phase offsets 0, 5 and 63 are measured in ticks from the sync pulse, which exposes a delay that counts phase instead of phase + 1. A power-down release that restarts the divider by itself is caught because the output must stay low until a fresh sync, and a sync sent during power-down must be ignored. A ratio rewritten mid-period must not cut the running period short. A source switch must change the measured period to the newly selected strobe's rate.

// File: rtl/chan_div_pkg.sv
package chan_div_pkg;

    localparam int RATIO_W    = 10;
    localparam int PHASE_W    = 6;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 2;
    localparam int NUM_SRC    = 2;
    localparam int SRC_SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int RATIO_HI_W = RATIO_W - DATA_W;

    localparam int PD_BIT  = 4;
    localparam int SEL_BIT = 5;

    localparam logic [ADDR_W-1:0] ADDR_RATIO_LO = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_CTRL     = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_PHASE    = ADDR_W'(2);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } div_state_e;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic               pd;
        logic               sel;
        logic [PHASE_W-1:0] phase;
    } div_cfg_t;

endpackage

// File: rtl/chan_div_regs.sv
module chan_div_regs
    import chan_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output div_cfg_t          cfg
);

    div_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            case (addr)
                ADDR_RATIO_LO: cfg_d.ratio[DATA_W-1:0] = wdata;
                ADDR_CTRL: begin
                    cfg_d.ratio[RATIO_W-1:DATA_W] = wdata[RATIO_HI_W-1:0];
                    cfg_d.pd  = wdata[PD_BIT];
                    cfg_d.sel = wdata[SEL_BIT];
                end
                ADDR_PHASE:    cfg_d.phase = wdata[PHASE_W-1:0];
                default:       cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/chan_div_tick_sel.sv
module chan_div_tick_sel
    import chan_div_pkg::*;
(
    input  logic [NUM_SRC-1:0]   src_en,
    input  logic [SRC_SEL_W-1:0] sel,
    output logic                 tick
);

    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel == SRC_SEL_W'(i)) begin
                tick = src_en[i];
            end
        end
    end

endmodule

// File: rtl/chan_div_core.sv
module chan_div_core
    import chan_div_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               sync,
    input  logic               pd,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [PHASE_W-1:0] phase,
    output logic               div_out,
    output div_state_e         state
);

    typedef struct packed {
        div_state_e         st;
        logic [RATIO_W-1:0] pos;
        logic [RATIO_W-1:0] lim;
        logic [PHASE_W-1:0] dly;
        logic               out;
    } core_t;

    core_t q, d;

    logic [RATIO_W:0]   hi_w;
    logic [RATIO_W-1:0] pos_inc;

    always_comb begin
        d       = q;
        hi_w    = ({1'b0, q.lim} + (RATIO_W+1)'(1)) >> 1;
        pos_inc = q.pos + RATIO_W'(1);

        if (pd) begin
            d.st  = ST_IDLE;
            d.pos = '0;
            d.dly = '0;
            d.out = 1'b0;
        end else if (sync) begin
            d.st  = ST_WAIT;
            d.pos = '0;
            d.dly = phase;
            d.out = 1'b0;
        end else begin
            case (q.st)
                ST_WAIT: begin
                    if (tick) begin
                        if (q.dly == '0) begin
                            d.st  = ST_RUN;
                            d.pos = '0;
                            d.lim = ratio;
                            d.out = 1'b1;
                        end else begin
                            d.dly = q.dly - PHASE_W'(1);
                        end
                    end
                end
                ST_RUN: begin
                    if (tick) begin
                        if (q.pos == q.lim) begin
                            d.pos = '0;
                            d.lim = ratio;
                            d.out = 1'b1;
                        end else begin
                            d.pos = pos_inc;
                            d.out = ({1'b0, pos_inc} < hi_w);
                        end
                    end else if (q.lim == '0) begin
                        d.out = 1'b0;
                    end
                end
                default: begin
                    d.out = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, pos: '0, lim: '0, dly: '0, out: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign div_out = q.out;
    assign state   = q.st;

endmodule

// File: rtl/chan_clk_div.sv
module chan_clk_div
    import chan_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_a_en,
    input  logic              pre_b_en,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              sync_in,
    output logic              div_out
);

    div_cfg_t   cfg_q;
    logic       tick;
    logic       pd_w;
    div_state_e core_st;

    chan_div_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg_q)
    );

    chan_div_tick_sel u_sel (
        .src_en ({pre_b_en, pre_a_en}),
        .sel    (SRC_SEL_W'(cfg_q.sel)),
        .tick   (tick)
    );

    assign pd_w = cfg_q.pd;

    chan_div_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .sync    (sync_in),
        .pd      (pd_w),
        .ratio   (cfg_q.ratio),
        .phase   (cfg_q.phase),
        .div_out (div_out),
        .state   (core_st)
    );

endmodule

// File: rtl/chan_clk_div_chk.sv
module chan_clk_div_chk
    import chan_div_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       pd,
    input logic       sync_in,
    input logic       tick,
    input div_state_e st,
    input logic       div_out
);

    AST_PD_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        pd |=> !div_out); // R5

    AST_SYNC_ENTERS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_in && !pd) |=> (st == ST_WAIT && !div_out)); // R3

    AST_WAIT_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT) |-> !div_out); // R3

    AST_IDLE_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !sync_in) |=> (st == ST_IDLE)); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !div_out); // R4

    AST_RISE_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !sync_in && !pd) |=> !$rose(div_out)); // R8

endmodule

bind chan_clk_div chan_clk_div_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pd      (pd_w),
    .sync_in (sync_in),
    .tick    (tick),
    .st      (core_st),
    .div_out (div_out)
);

// File: tb/chan_clk_div_tb_top.sv
`timescale 1ns/1ps
module chan_clk_div_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam int  GUARD      = 6000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pre_a_en = 1'b0;
    logic       pre_b_en = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       sync_in = 1'b0;
    logic       div_out;

    int n_chk = 0;
    int n_bad = 0;
    int a_div = 1;
    int b_div = 1;
    int a_cnt = 0;
    int b_cnt = 0;

    chan_clk_div dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pre_a_en  (pre_a_en),
        .pre_b_en  (pre_b_en),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .sync_in   (sync_in),
        .div_out   (div_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        a_cnt = (a_cnt + 1 >= a_div) ? 0 : a_cnt + 1;
        b_cnt = (b_cnt + 1 >= b_div) ? 0 : b_cnt + 1;
        pre_a_en = (a_cnt == 0);
        pre_b_en = (b_cnt == 0);
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic pulse_sync();
        @(negedge clk);
        sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
    endtask

    task automatic wait_rise(output int d);
        d = 0;
        while (!div_out && d < GUARD) begin
            @(negedge clk);
            d++;
        end
    endtask

    task automatic meas(output int h, output int p);
        h = 1; p = 0;
        while (p < GUARD) begin
            @(negedge clk);
            p++;
            if (div_out) h++;
            else break;
        end
        while (p < GUARD) begin
            @(negedge clk);
            p++;
            if (div_out) break;
        end
    endtask

    task automatic count_high(input int cycles, output int highs);
        highs = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (div_out) highs++;
        end
    endtask

    task automatic t_reset();
        int highs, d, h, p;
        a_div = 1;
        count_high(30, highs);
        chk("R4", "output before first sync", highs, 0);
        pulse_sync();
        wait_rise(d);
        chk("R4", "default phase first rise", d, 1);
        count_high(10, highs);
        chk("R4", "default divide-by-1 stays high", highs, 10);
    endtask

    task automatic t_ratio(input int field, input int adiv, input int ph);
        int d, h, p, n, exp_h;
        n = field + 1;
        a_div = adiv;
        wr_reg(2'd0, 8'(field));
        wr_reg(2'd1, 8'(field >> 8));
        wr_reg(2'd2, 8'(ph));
        pulse_sync();
        wait_rise(d);
        if (adiv == 1) chk("R3", $sformatf("first rise phase %0d", ph), d, ph + 1);
        meas(h, p);
        exp_h = (n == 1) ? 1 : (n / 2) * adiv;
        chk("R2", $sformatf("high time N=%0d", n), h, exp_h);
        chk("R1", $sformatf("period N=%0d", n), p, n * adiv);
    endtask

    task automatic t_powerdown();
        int d, highs;
        a_div = 1;
        wr_reg(2'd0, 8'd3);
        wr_reg(2'd2, 8'd0);
        wr_reg(2'd1, 8'h00);
        pulse_sync();
        wait_rise(d);
        wr_reg(2'd1, 8'h10);
        count_high(20, highs);
        chk("R5", "output while powered down", highs, 0);
        pulse_sync();
        count_high(20, highs);
        chk("R5", "sync ignored in power-down", highs, 0);
        wr_reg(2'd1, 8'h00);
        count_high(40, highs);
        chk("R6", "output after release without sync", highs, 0);
        pulse_sync();
        wait_rise(d);
        chk("R6", "first rise after release and sync", d, 1);
    endtask

    task automatic t_change();
        int d, h, p;
        a_div = 1;
        wr_reg(2'd0, 8'd3);
        wr_reg(2'd1, 8'h00);
        wr_reg(2'd2, 8'd0);
        pulse_sync();
        wait_rise(d);
        @(negedge clk);
        wr_reg(2'd0, 8'd5);
        d = 3;
        while (!div_out && d < GUARD) begin
            @(negedge clk);
            d++;
        end
        chk("R7", "period in progress keeps old ratio", d, 4);
        meas(h, p);
        chk("R7", "new ratio high time", h, 3);
        chk("R7", "new ratio period", p, 6);
    endtask

    task automatic t_select();
        int d, h, p;
        a_div = 1;
        b_div = 3;
        wr_reg(2'd0, 8'd2);
        wr_reg(2'd2, 8'd0);
        wr_reg(2'd1, 8'h20);
        pulse_sync();
        wait_rise(d);
        meas(h, p);
        chk("R8", "source B high time", h, 3);
        chk("R8", "source B period", p, 9);
        wr_reg(2'd1, 8'h00);
        d = 0;
        while (div_out && d < GUARD) begin
            @(negedge clk);
            d++;
        end
        wait_rise(d);
        meas(h, p);
        chk("R8", "source A period after switch", p, 3);
        chk("R8", "source A high time after switch", h, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ratio(0, 2, 0);
        t_ratio(1, 1, 0);
        t_ratio(2, 1, 5);
        t_ratio(6, 1, 0);
        t_ratio(6, 2, 3);
        t_ratio(1023, 1, 63);
        t_powerdown();
        t_change();
        t_select();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule